// File: doc/BRIEF.md
# IMA Receive Cell Smoothing Buffer

This block sits between the receive reorder stage of an inverse-multiplexed ATM group and the ATM layer. Reordered cells arrive with the control cells already stripped out. Each cell arrives as a descriptor made of a cell handle and a flag that marks it as Filler or data, and the block writes it into a small FIFO. The recovered receive data-cell clock presents a tick. On each tick exactly one descriptor leaves the FIFO. A data cell goes to the ATM layer, and a Filler is dropped without trace. Because the read pace comes from the recovered clock and not from the consumer, the gaps that the stripped control cells left in the stream are evened out.

A second function decides which incoming link the receive cell clock follows. The far end keeps reporting which of its links is its timing reference. The block adopts that link as the clock source only after the report has stayed on one link, with that link Working, for a programmable number of millisecond strobes (100 by default). Until then the previous source is kept.

Top module: `ima_rx_smoother`

## Requirements
- R1: A write (`wr_valid` high) into a buffer that is not full is accepted, and cells leave in the order they were written, each with its own handle and Filler flag (`wr_filler` = 1 marks Filler).
- R2: Each cycle with `cell_tick` high removes exactly one cell from a non-empty buffer, and its outcome appears on the outputs in the following cycle.
- R3: A removed cell whose Filler flag is 1 is discarded: `out_valid` stays low in the following cycle.
- R4: A removed cell whose Filler flag is 0 is forwarded: `out_valid` is high for one cycle, with `out_handle` equal to the written handle.
- R5: A tick while the buffer is empty raises `underflow` for one cycle in the following cycle and forwards nothing.
- R6: A write while the buffer holds DEPTH cells, without a tick removing a cell in the same cycle, is refused: the contents stay unchanged and `overflow` is high for one cycle in the following cycle. A write with no such conflict never raises `overflow`.
- R7: In a cycle without a tick no cell is removed, and in the next cycle `out_valid` and `underflow` are low.
- R8: `clk_src_link` takes the value of `fe_ref_link`, and `clk_src_valid` goes high and stays high, in the cycle after QUAL_MS strobes of `ms_strobe` have been counted while `fe_ref_link` was steady and `fe_ref_working` was high. Before that count is reached, the source does not change.
- R9: A change of `fe_ref_link`, or `fe_ref_working` going low, restarts the strobe count from zero. While `fe_ref_working` is low the clock source is held.
- R10: After reset the buffer is empty, all output pulses are low, `clk_src_valid` is 0 and `clk_src_link` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write a cell descriptor this cycle |
| wr_handle | input | HANDLE_W | Handle of the cell being written |
| wr_filler | input | 1 | 1 marks the written cell as Filler |
| cell_tick | input | 1 | Receive data-cell clock tick |
| out_valid | output | 1 | Data cell forwarded to the ATM layer |
| out_handle | output | HANDLE_W | Handle of the forwarded cell |
| underflow | output | 1 | A tick found the buffer empty |
| overflow | output | 1 | A write was refused because the buffer was full |
| ms_strobe | input | 1 | One-cycle pulse every millisecond |
| fe_ref_link | input | LINK_W | Reference link reported by the far end |
| fe_ref_working | input | 1 | The reported link is in the Working state |
| clk_src_link | output | LINK_W | Link the receive cell clock follows |
| clk_src_valid | output | 1 | A qualified source has been adopted |

## Verification
The bench sweeps every fill level from empty to full. At each level it adds a write that collides with a full buffer and a write that coincides with a tick, then drains the buffer past empty. A design that checks fullness before honouring a simultaneous pop refuses a cell it should keep. A design that overwrites on overflow, or mixes up Filler and data, shows up as a wrong handle or wrong valid pulse on a later read. For the reference link, the bench stops one strobe short of the threshold and then supplies the last strobe. It also changes the link partway through a count and drops the Working state partway through a count. An off-by-one counter, or a counter that does not restart, moves the clock source a strobe early or late, or moves it to a stale link.

// File: rtl/ima_smooth_pkg.sv
package ima_smooth_pkg;

    localparam int unsigned DEF_DEPTH    = 8;
    localparam int unsigned DEF_HANDLE_W = 12;
    localparam int unsigned DEF_LINK_W   = 5;
    localparam int unsigned DEF_QUAL_MS  = 100;

    // Outcome of one read slot
    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_DATA   = 2'd1,
        RD_FILLER = 2'd2,
        RD_EMPTY  = 2'd3
    } rd_kind_e;

endpackage

// File: rtl/smooth_fifo.sv
module smooth_fifo
    import ima_smooth_pkg::*;
#(
    parameter int unsigned DEPTH    = DEF_DEPTH,
    parameter int unsigned HANDLE_W = DEF_HANDLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [HANDLE_W-1:0] push_handle,
    input  logic                push_filler,
    input  logic                tick,
    output rd_kind_e            rd_kind,
    output logic [HANDLE_W-1:0] rd_handle,
    output logic                push_refused
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic                filler;
        logic [HANDLE_W-1:0] handle;
    } desc_t;

    typedef struct packed {
        desc_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]  rd_ptr;
        logic [PTR_W-1:0]  wr_ptr;
        logic [CNT_W-1:0]  count;
    } fifo_state_t;

    fifo_state_t s_d, s_q;

    logic  empty, full, pop, accept;
    desc_t head;

    always_comb begin
        s_d    = s_q;
        head   = s_q.mem[s_q.rd_ptr];
        empty  = (s_q.count == '0);
        full   = (s_q.count == FULL_CNT);
        pop    = tick && !empty;
        // a pop in the same cycle frees the slot the write needs
        accept = push && (!full || pop);

        if (!tick)            rd_kind = RD_NONE;
        else if (empty)       rd_kind = RD_EMPTY;
        else if (head.filler) rd_kind = RD_FILLER;
        else                  rd_kind = RD_DATA;
        rd_handle    = head.handle;
        push_refused = push && !accept;

        if (pop) begin
            s_d.rd_ptr = (s_q.rd_ptr == LAST_PTR) ? '0 : s_q.rd_ptr + 1'b1;
        end
        if (accept) begin
            s_d.mem[s_q.wr_ptr] = '{filler: push_filler, handle: push_handle};
            s_d.wr_ptr = (s_q.wr_ptr == LAST_PTR) ? '0 : s_q.wr_ptr + 1'b1;
        end
        case ({accept, pop})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/ref_qualifier.sv
module ref_qualifier
    import ima_smooth_pkg::*;
#(
    parameter int unsigned LINK_W  = DEF_LINK_W,
    parameter int unsigned QUAL_MS = DEF_QUAL_MS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_strobe,
    input  logic [LINK_W-1:0] ind_link,
    input  logic              ind_working,
    output logic [LINK_W-1:0] sel_link,
    output logic              sel_valid
);

    localparam int unsigned CNT_W = $clog2(QUAL_MS + 1);
    localparam logic [CNT_W-1:0] QUAL_CNT = CNT_W'(QUAL_MS);

    typedef struct packed {
        logic [LINK_W-1:0] last_link;
        logic [CNT_W-1:0]  cnt;
        logic [LINK_W-1:0] sel_link;
        logic              sel_valid;
    } qual_state_t;

    qual_state_t s_d, s_q;
    logic steady;

    always_comb begin
        s_d           = s_q;
        steady        = ind_working && (ind_link == s_q.last_link);
        s_d.last_link = ind_link;

        if (!steady) begin
            s_d.cnt = '0;
        end else if (ms_strobe && (s_q.cnt < QUAL_CNT)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end

        if (steady && (s_q.cnt == QUAL_CNT)) begin
            s_d.sel_link  = s_q.last_link;
            s_d.sel_valid = 1'b1;
        end

        sel_link  = s_q.sel_link;
        sel_valid = s_q.sel_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/ima_rx_smoother.sv
module ima_rx_smoother
    import ima_smooth_pkg::*;
#(
    parameter int unsigned DEPTH    = DEF_DEPTH,
    parameter int unsigned HANDLE_W = DEF_HANDLE_W,
    parameter int unsigned LINK_W   = DEF_LINK_W,
    parameter int unsigned QUAL_MS  = DEF_QUAL_MS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [HANDLE_W-1:0] wr_handle,
    input  logic                wr_filler,
    input  logic                cell_tick,
    output logic                out_valid,
    output logic [HANDLE_W-1:0] out_handle,
    output logic                underflow,
    output logic                overflow,
    input  logic                ms_strobe,
    input  logic [LINK_W-1:0]   fe_ref_link,
    input  logic                fe_ref_working,
    output logic [LINK_W-1:0]   clk_src_link,
    output logic                clk_src_valid
);

    typedef struct packed {
        logic                valid;
        logic [HANDLE_W-1:0] handle;
        logic                under;
        logic                over;
    } out_state_t;

    out_state_t o_d, o_q;

    rd_kind_e            rd_kind;
    logic [HANDLE_W-1:0] rd_handle;
    logic                push_refused;

    smooth_fifo #(
        .DEPTH    (DEPTH),
        .HANDLE_W (HANDLE_W)
    ) i_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (wr_valid),
        .push_handle  (wr_handle),
        .push_filler  (wr_filler),
        .tick         (cell_tick),
        .rd_kind      (rd_kind),
        .rd_handle    (rd_handle),
        .push_refused (push_refused)
    );

    ref_qualifier #(
        .LINK_W  (LINK_W),
        .QUAL_MS (QUAL_MS)
    ) i_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_strobe   (ms_strobe),
        .ind_link    (fe_ref_link),
        .ind_working (fe_ref_working),
        .sel_link    (clk_src_link),
        .sel_valid   (clk_src_valid)
    );

    always_comb begin
        o_d.valid  = (rd_kind == RD_DATA);
        o_d.handle = (rd_kind == RD_DATA) ? rd_handle : '0;
        o_d.under  = (rd_kind == RD_EMPTY);
        o_d.over   = push_refused;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid  = o_q.valid;
    assign out_handle = o_q.handle;
    assign underflow  = o_q.under;
    assign overflow   = o_q.over;

endmodule

// File: rtl/smoother_checker.sv
module smoother_checker #(
    parameter int unsigned LINK_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              cell_tick,
    input logic              out_valid,
    input logic              underflow,
    input logic              overflow,
    input logic              fe_ref_working,
    input logic [LINK_W-1:0] clk_src_link,
    input logic              clk_src_valid
);

    assert_quiet_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_tick |=> (!out_valid && !underflow));

    assert_underflow_forwards_nothing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> !out_valid);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !overflow);

    assert_source_held_when_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_ref_working |=> ($stable(clk_src_link) && $stable(clk_src_valid)));

    assert_source_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_src_valid |=> clk_src_valid);

endmodule

bind ima_rx_smoother smoother_checker #(.LINK_W(LINK_W)) i_smoother_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .cell_tick      (cell_tick),
    .out_valid      (out_valid),
    .underflow      (underflow),
    .overflow       (overflow),
    .fe_ref_working (fe_ref_working),
    .clk_src_link   (clk_src_link),
    .clk_src_valid  (clk_src_valid)
);

// File: tb/test_ima_rx_smoother.sv
`timescale 1ns/1ps
module test_ima_rx_smoother;

    localparam int DEPTH = 8;
    localparam int HW    = 12;
    localparam int LW    = 5;
    localparam int QMS   = 100;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_valid, wr_filler, cell_tick, ms_strobe, fe_ref_working;
    logic [HW-1:0] wr_handle;
    logic [LW-1:0] fe_ref_link;
    logic          out_valid, underflow, overflow, clk_src_valid;
    logic [HW-1:0] out_handle;
    logic [LW-1:0] clk_src_link;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic [HW:0] mdl[$];

    always #2.5 clk = ~clk;

    ima_rx_smoother #(.DEPTH(DEPTH), .HANDLE_W(HW), .LINK_W(LW), .QUAL_MS(QMS)) i_ima_rx_smoother (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_handle(wr_handle),
        .wr_filler(wr_filler), .cell_tick(cell_tick), .out_valid(out_valid),
        .out_handle(out_handle), .underflow(underflow), .overflow(overflow),
        .ms_strobe(ms_strobe), .fe_ref_link(fe_ref_link), .fe_ref_working(fe_ref_working),
        .clk_src_link(clk_src_link), .clk_src_valid(clk_src_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // one FIFO cycle, driven and checked at negedges against a queue model
    task automatic cyc(input logic wv, input logic [HW-1:0] wh, input logic wf, input logic tk);
        logic          exp_v = 1'b0, exp_u = 1'b0, exp_o = 1'b0;
        logic [HW-1:0] exp_h = '0;
        logic [HW:0]   e;
        int            sz = mdl.size();
        wr_valid = wv; wr_handle = wh; wr_filler = wf; cell_tick = tk;
        if (tk) begin
            if (sz == 0) exp_u = 1'b1;
            else begin
                e = mdl.pop_front();
                exp_v = !e[HW];
                exp_h = e[HW-1:0];
            end
        end
        if (wv) begin
            if (sz < DEPTH || (tk && sz > 0)) mdl.push_back({wf, wh});
            else exp_o = 1'b1;
        end
        @(negedge clk);
        wr_valid = 1'b0; cell_tick = 1'b0;
        chk(tk ? (sz == 0 ? "R5 empty tick" : (exp_v ? "R2 R4 data out" : "R2 R3 filler drop"))
               : "R7 no tick", {31'd0, out_valid}, {31'd0, exp_v});
        if (exp_v) chk("R1 R4 handle order", {20'd0, out_handle}, {20'd0, exp_h});
        chk("R5 underflow", {31'd0, underflow}, {31'd0, exp_u});
        chk("R6 overflow", {31'd0, overflow}, {31'd0, exp_o});
    endtask

    task automatic strobes(input int n);
        for (int k = 0; k < n; k++) begin
            ms_strobe = 1'b1; @(negedge clk);
            ms_strobe = 1'b0; @(negedge clk);
        end
    endtask

    task automatic chk_src(input string tag, input logic v, input logic [LW-1:0] l);
        chk(tag, {31'd0, clk_src_valid}, {31'd0, v});
        chk(tag, {27'd0, clk_src_link}, {27'd0, l});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_valid = 0; wr_handle = '0; wr_filler = 0; cell_tick = 0;
        ms_strobe = 0; fe_ref_link = '0; fe_ref_working = 0;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {31'd0, out_valid}, 0);
        chk("R10 reset underflow", {31'd0, underflow}, 0);
        chk("R10 reset overflow", {31'd0, overflow}, 0);
        chk_src("R10 reset source", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep every fill level, collide with full, drain past empty
        for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            for (int i = 0; i < lvl; i++)
                cyc(1'b1, HW'(lvl * 16 + i), ((lvl + i) % 3 == 0), 1'b0);
            cyc(1'b1, HW'(lvl * 16 + 9), 1'b0, 1'b0);
            cyc(1'b1, HW'(lvl * 16 + 10), 1'b0, 1'b0);
            cyc(1'b1, HW'(lvl * 16 + 11), (lvl % 2 == 1), 1'b1);
            for (int i = 0; i < DEPTH + 3; i++) cyc(1'b0, '0, 1'b0, 1'b1);
        end

        // interleaved traffic
        for (int i = 0; i < 400; i++)
            cyc((i % 2 == 0) || (i % 5 == 0), HW'(i * 7 + 3), (i % 7 == 0), (i % 3 != 0));
        for (int i = 0; i < DEPTH + 2; i++) cyc(1'b0, '0, 1'b0, 1'b1);

        // reference link qualification
        fe_ref_link = 5'd5; fe_ref_working = 1'b1; @(negedge clk);
        strobes(QMS - 1);
        chk_src("R8 one strobe short", 1'b0, '0);
        strobes(1);
        chk_src("R8 adopted", 1'b1, 5'd5);

        fe_ref_link = 5'd9; @(negedge clk);
        strobes(50);
        fe_ref_link = 5'd3; @(negedge clk);
        strobes(QMS - 1);
        chk_src("R9 restart on link change", 1'b1, 5'd5);
        strobes(1);
        chk_src("R8 new link adopted", 1'b1, 5'd3);

        fe_ref_link = 5'd7; @(negedge clk);
        strobes(60);
        fe_ref_working = 1'b0; @(negedge clk);
        fe_ref_working = 1'b1; @(negedge clk);
        strobes(QMS - 1);
        chk_src("R9 restart on working drop", 1'b1, 5'd3);
        strobes(1);
        chk_src("R8 adopted after restart", 1'b1, 5'd7);

        fe_ref_working = 1'b0; fe_ref_link = 5'd2; @(negedge clk);
        strobes(QMS + 20);
        chk_src("R9 held while not working", 1'b1, 5'd7);

        done = 1;
        report();
        $finish;
    end

endmodule